// File: doc/BRIEF.md
# Processor Condition Code Register

This block holds a 16-bit processor condition word. The upper byte holds a stop-control bit and seven status flags. The lower byte holds a 3-bit interrupt priority level, a saturation mode bit and a 4-bit program address extension. Each cycle the ALU presents a result value, a width select and the carry and overflow indications it produced. A 7-bit enable vector chooses which flags take their new values in that cycle. A full-word write port loads all sixteen bits at once, for example when the word is restored from a stack or moved from a register.

The packed word and every field are available as outputs. A stop request output tells the low-power controller whether an executing stop instruction should halt the clock. When the stop-control bit is set, the instruction is treated as a no-op instead. The ALU, the stop controller and interrupt arbitration sit outside this block.

Top module: `ccr_unit`

## Requirements
- R1: After the asynchronous reset, `ccr_o` is 16'h00E0: every flag, the stop-control bit, the saturation bit and the address extension are 0, and the priority level is 3'b111.
- R2: When `wr_en_i` is high at a clock edge, `ccr_o` equals `wr_data_i` after that edge, whatever `flag_en_i` holds.
- R3: The negative flag sits at bit 11 and is updated by `flag_en_i[3]`. When `res_word_i` is 1 it takes bit 15 of `res_i`; when `res_word_i` is 0 it takes bit 7.
- R4: The zero flag sits at bit 10 and is updated by `flag_en_i[2]`. It becomes 1 exactly when all bits of the active width (16 bits, or the low 8 bits) of `res_i` are 0.
- R5: The overflow flag sits at bit 9 and is loaded from `ovf_i` under `flag_en_i[1]`. The carry flag sits at bit 8 and is loaded from `carry_i` under `flag_en_i[0]`.
- R6: The BCD half-carry flag sits at bit 13 and is loaded from `half_carry_i` under `flag_en_i[5]`.
- R7: The bit-31 accumulator overflow flag sits at bit 12 and is loaded from `ovf31_i` under `flag_en_i[4]`. The bit-35 accumulator overflow flag sits at bit 14 and is loaded from `ovf35_i` under `flag_en_i[6]`.
- R8: Without a write, a flag whose enable is 0 keeps its value. Bits 15 and 7..0 change only through the write port.
- R9: `stop_req_o` is high exactly when `stop_exec_i` is high and the stop-control bit (bit 15) is 0.
- R10: The field outputs are fixed slices of `ccr_o`: `s_o`=15, `mv_o`=14, `h_o`=13, `ev_o`=12, `n_o`=11, `z_o`=10, `v_o`=9, `c_o`=8, `ip_o`=7..5, `sm_o`=4 and `pk_o`=3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_i | input | 16 | ALU result |
| res_word_i | input | 1 | 1 = 16-bit result, 0 = 8-bit result |
| half_carry_i | input | 1 | Carry out of bit 3 during BCD add |
| ovf31_i | input | 1 | Overflow into accumulator bit 31 |
| ovf35_i | input | 1 | Overflow into accumulator bit 35 |
| ovf_i | input | 1 | Two's complement overflow |
| carry_i | input | 1 | Carry/borrow out |
| flag_en_i | input | 7 | Per-flag update enables, bit i drives word bit 8+i |
| wr_en_i | input | 1 | Full-word load |
| wr_data_i | input | 16 | Full-word load value |
| stop_exec_i | input | 1 | Stop instruction executing |
| ccr_o | output | 16 | Packed register |
| s_o | output | 1 | Stop-control bit |
| mv_o | output | 1 | Bit-35 overflow flag |
| h_o | output | 1 | Half-carry flag |
| ev_o | output | 1 | Bit-31 overflow flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |
| ip_o | output | 3 | Interrupt priority level |
| sm_o | output | 1 | Saturation mode bit |
| pk_o | output | 4 | Program address extension |
| stop_req_o | output | 1 | Clock stop request |

## Verification
The hardest case to reach from the ports is a cycle where a full-word write and flag updates collide. The write must win even when all seven enables are set and the ALU inputs disagree with the written value. The stimulus sweeps every enable pattern against a stream of results that includes all-zero words, words whose only zero byte is the low one, and both widths. Writes are interleaved periodically during that sweep. A directed collision with all enables high checks the override explicitly. The written words vary the stop-control bit, so the stop request is observed under both settings.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_W     = 16;
  localparam int NUM_FLAGS = 7;
  localparam int IP_W      = 3;
  localparam int PK_W      = 4;

  // flag index inside the bank; word bit = FLAG_LSB + index
  localparam int FL_C  = 0;
  localparam int FL_V  = 1;
  localparam int FL_Z  = 2;
  localparam int FL_N  = 3;
  localparam int FL_EV = 4;
  localparam int FL_H  = 5;
  localparam int FL_MV = 6;

  localparam int PK_LSB   = 0;
  localparam int SM_POS   = PK_LSB + PK_W;
  localparam int IP_LSB   = SM_POS + 1;
  localparam int FLAG_LSB = IP_LSB + IP_W;
  localparam int S_POS    = FLAG_LSB + NUM_FLAGS;

  localparam logic [IP_W-1:0] IP_RST = '1;
endpackage

// File: rtl/ccr_result_eval.sv
module ccr_result_eval #(
  parameter int RES_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic [RES_W-1:0] res_i,
  input  logic             wide_i,
  output logic             neg_o,
  output logic             zero_o
);
  generate
    if (NARROW_W < RES_W) begin : g_two_width
      always_comb begin
        if (wide_i) begin
          neg_o  = res_i[RES_W-1];
          zero_o = ~|res_i;
        end else begin
          neg_o  = res_i[NARROW_W-1];
          zero_o = ~|res_i[NARROW_W-1:0];
        end
      end
    end else begin : g_one_width
      logic unused_wide;
      assign unused_wide = wide_i;
      assign neg_o  = res_i[RES_W-1];
      assign zero_o = ~|res_i;
    end
  endgenerate
endmodule

// File: rtl/ccr_flag_bank.sv
module ccr_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] next_i,
  input  logic [N-1:0] en_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_i,
  output logic [N-1:0] q_o
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q_o[g] <= 1'b0;
        else if (wr_en_i)  q_o[g] <= wr_i[g];   // write beats update
        else if (en_i[g])  q_o[g] <= next_i[g];
      end
    end
  endgenerate
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int RES_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [RES_W-1:0]     res_i,
  input  logic                 res_word_i,
  input  logic                 half_carry_i,
  input  logic                 ovf31_i,
  input  logic                 ovf35_i,
  input  logic                 ovf_i,
  input  logic                 carry_i,
  input  logic [NUM_FLAGS-1:0] flag_en_i,
  input  logic                 wr_en_i,
  input  logic [CCR_W-1:0]     wr_data_i,
  input  logic                 stop_exec_i,
  output logic [CCR_W-1:0]     ccr_o,
  output logic                 s_o,
  output logic                 mv_o,
  output logic                 h_o,
  output logic                 ev_o,
  output logic                 n_o,
  output logic                 z_o,
  output logic                 v_o,
  output logic                 c_o,
  output logic [IP_W-1:0]      ip_o,
  output logic                 sm_o,
  output logic [PK_W-1:0]      pk_o,
  output logic                 stop_req_o
);
  logic                 n_calc, z_calc;
  logic [NUM_FLAGS-1:0] flag_next, flag_q;
  logic                 s_q, sm_q;
  logic [IP_W-1:0]      ip_q;
  logic [PK_W-1:0]      pk_q;

  ccr_result_eval #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_eval (
    .res_i  (res_i),
    .wide_i (res_word_i),
    .neg_o  (n_calc),
    .zero_o (z_calc)
  );

  always_comb begin
    flag_next        = '0;
    flag_next[FL_C]  = carry_i;
    flag_next[FL_V]  = ovf_i;
    flag_next[FL_Z]  = z_calc;
    flag_next[FL_N]  = n_calc;
    flag_next[FL_EV] = ovf31_i;
    flag_next[FL_H]  = half_carry_i;
    flag_next[FL_MV] = ovf35_i;
  end

  ccr_flag_bank #(.N(NUM_FLAGS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .next_i  (flag_next),
    .en_i    (flag_en_i),
    .wr_en_i (wr_en_i),
    .wr_i    (wr_data_i[FLAG_LSB +: NUM_FLAGS]),
    .q_o     (flag_q)
  );

  // control fields move only on a full write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q  <= 1'b0;
      sm_q <= 1'b0;
      ip_q <= IP_RST;
      pk_q <= '0;
    end else if (wr_en_i) begin
      s_q  <= wr_data_i[S_POS];
      sm_q <= wr_data_i[SM_POS];
      ip_q <= wr_data_i[IP_LSB +: IP_W];
      pk_q <= wr_data_i[PK_LSB +: PK_W];
    end
  end

  always_comb begin
    ccr_o                        = '0;
    ccr_o[S_POS]                 = s_q;
    ccr_o[FLAG_LSB +: NUM_FLAGS] = flag_q;
    ccr_o[IP_LSB +: IP_W]        = ip_q;
    ccr_o[SM_POS]                = sm_q;
    ccr_o[PK_LSB +: PK_W]        = pk_q;
  end

  assign s_o  = s_q;
  assign mv_o = flag_q[FL_MV];
  assign h_o  = flag_q[FL_H];
  assign ev_o = flag_q[FL_EV];
  assign n_o  = flag_q[FL_N];
  assign z_o  = flag_q[FL_Z];
  assign v_o  = flag_q[FL_V];
  assign c_o  = flag_q[FL_C];
  assign ip_o = ip_q;
  assign sm_o = sm_q;
  assign pk_o = pk_q;

  assign stop_req_o = stop_exec_i & ~s_q;
endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk
  import ccr_pkg::*;
#(
  parameter int RES_W    = 16,
  parameter int NARROW_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [RES_W-1:0]     res_i,
  input logic                 res_word_i,
  input logic                 ovf_i,
  input logic                 carry_i,
  input logic [NUM_FLAGS-1:0] flag_en_i,
  input logic                 wr_en_i,
  input logic [CCR_W-1:0]     wr_data_i,
  input logic                 stop_exec_i,
  input logic [CCR_W-1:0]     ccr_o,
  input logic                 s_o,
  input logic                 n_o,
  input logic                 v_o,
  input logic                 c_o,
  input logic [IP_W-1:0]      ip_o,
  input logic                 stop_req_o
);
  a_r2_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ccr_o == $past(wr_data_i));

  a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && flag_en_i == '0) |=> $stable(ccr_o));

  a_r8_ctrl_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(s_o) && $stable(ip_o)));

  a_r3_neg_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && flag_en_i[FL_N] && res_word_i) |=> n_o == $past(res_i[RES_W-1]));

  a_r3_neg_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && flag_en_i[FL_N] && !res_word_i) |=> n_o == $past(res_i[NARROW_W-1]));

  a_r5_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && flag_en_i[FL_C]) |=> c_o == $past(carry_i));

  a_r5_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && flag_en_i[FL_V]) |=> v_o == $past(ovf_i));

  a_r9_stop_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_o |-> !stop_req_o);

  a_r9_stop_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_o |-> stop_req_o == stop_exec_i);
endmodule

bind ccr_unit ccr_unit_chk #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/test_ccr_unit.sv
module test_ccr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] res_i = '0;
  logic        res_word_i = 1'b0;
  logic        half_carry_i = 1'b0, ovf31_i = 1'b0, ovf35_i = 1'b0;
  logic        ovf_i = 1'b0, carry_i = 1'b0;
  logic [6:0]  flag_en_i = '0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        stop_exec_i = 1'b0;
  logic [15:0] ccr_o;
  logic        s_o, mv_o, h_o, ev_o, n_o, z_o, v_o, c_o, sm_o, stop_req_o;
  logic [2:0]  ip_o;
  logic [3:0]  pk_o;

  int checks = 0;
  int failures = 0;
  logic [15:0] model;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ccr_unit i_ccr_unit (.*);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_fields();
    logic [15:0] f;
    f = {s_o, mv_o, h_o, ev_o, n_o, z_o, v_o, c_o, ip_o, sm_o, pk_o};
    chk(f == ccr_o, "R10 field slices", f, ccr_o);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // apply one cycle: drive at negedge, check stop pre-edge, check state post-edge
  task automatic step(input logic [15:0] res, input logic word, input logic [6:0] en,
                      input logic [4:0] bits, input logic wr, input logic [15:0] wd,
                      input logic stop);
    logic [15:0] nxt;
    logic nv, zv;
    @(negedge clk_i);
    res_i = res; res_word_i = word; flag_en_i = en;
    {ovf35_i, half_carry_i, ovf31_i, ovf_i, carry_i} = bits;
    wr_en_i = wr; wr_data_i = wd; stop_exec_i = stop;
    #1;
    chk(stop_req_o == (stop && !model[15]), "R9 stop_req", {15'b0, stop_req_o},
        {15'b0, stop && !model[15]});
    nv = word ? res[15] : res[7];
    zv = word ? (res == 16'h0) : (res[7:0] == 8'h0);
    nxt = model;
    if (wr) nxt = wd;
    else begin
      if (en[0]) nxt[8]  = bits[0];
      if (en[1]) nxt[9]  = bits[1];
      if (en[2]) nxt[10] = zv;
      if (en[3]) nxt[11] = nv;
      if (en[4]) nxt[12] = bits[2];
      if (en[5]) nxt[13] = bits[3];
      if (en[6]) nxt[14] = bits[4];
    end
    @(posedge clk_i);
    #1;
    if (wr) chk(ccr_o == nxt, "R2 full write", ccr_o, nxt);
    else begin
      chk(ccr_o[11] == nxt[11], "R3 negative", {15'b0, ccr_o[11]}, {15'b0, nxt[11]});
      chk(ccr_o[10] == nxt[10], "R4 zero", {15'b0, ccr_o[10]}, {15'b0, nxt[10]});
      chk(ccr_o[9:8] == nxt[9:8], "R5 overflow/carry", {14'b0, ccr_o[9:8]}, {14'b0, nxt[9:8]});
      chk(ccr_o[13] == nxt[13], "R6 half carry", {15'b0, ccr_o[13]}, {15'b0, nxt[13]});
      chk({ccr_o[14], ccr_o[12]} == {nxt[14], nxt[12]}, "R7 accum overflow",
          {14'b0, ccr_o[14], ccr_o[12]}, {14'b0, nxt[14], nxt[12]});
      chk(ccr_o == nxt, "R8 hold/control fields", ccr_o, nxt);
    end
    check_fields();
    model = nxt;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] r, h;
    repeat (3) @(posedge clk_i);
    #1;
    chk(ccr_o == 16'h00E0, "R1 reset value", ccr_o, 16'h00E0);
    check_fields();
    @(negedge clk_i);
    rst_ni = 1'b1;
    model = 16'h00E0;

    // R8: idle cycle with data toggling leaves state untouched
    step(16'hFFFF, 1'b1, 7'h00, 5'h1F, 1'b0, 16'hFFFF, 1'b1);

    // R2: write with all enables set and conflicting ALU inputs
    step(16'h0000, 1'b1, 7'h7F, 5'h1F, 1'b1, 16'h8A15, 1'b1);
    step(16'h0000, 1'b1, 7'h00, 5'h00, 1'b0, 16'h0000, 1'b1);
    step(16'h8000, 1'b1, 7'h7F, 5'h00, 1'b1, 16'h7F00, 1'b1);

    // sweep all enable patterns over assorted results and widths
    for (int i = 0; i < 2048; i++) begin
      h = 16'(i * 7919 + 13);
      case (i % 6)
        0: r = 16'h0000;
        1: r = {h[15:8] | 8'h01, 8'h00};
        2: r = 16'h0080;
        3: r = 16'h8001;
        default: r = 16'(i * 40503);
      endcase
      step(r, i[7], 7'(i), h[4:0], (i % 53) == 7, {h[3], h[11:0] ^ 12'hA5C, h[6:4]}, h[9]);
    end
    finish_run();
  end
endmodule